// File: doc/BRIEF.md
# Back-to-Front Command Queue with Drain Fence

This block buffers command words travelling from an execution back end to an instruction-fetch front end, and it holds the small amount of consumer-side control that decides when a command leaves the buffer. The producer writes with a ready-then-valid handshake: it may present a command only while the queue signals room, and it stalls when the queue is full, so nothing is ever lost. There is no clear operation. Every stored command stays until the consumer takes it, and only a reset empties the queue.

Each command carries an opcode in its most significant bits. The block sorts opcodes into three classes. Prediction-feedback commands are removed the same cycle they reach the head, whether or not the consumer is ready and whether or not another command is in progress. Redirecting commands, which move the fetch address or alter shadow state, raise a one-cycle flush strobe for the fetch queue that flows in the other direction. Every non-feedback command may take several cycles to carry out. While one is in progress the block offers no further non-feedback command, and the consumer ends it with a done strobe.

A registered fence output tells the producer that the queue is empty and no command is still being carried out. The fence drops on the edge that stores a command. It rises one cycle after the queue has become empty and idle, so its rise lags the drain.

Top module: `cmd_fence_queue`

## Requirements
- R1: After reset the queue is empty: `prod_ready_o`=1, `cons_valid_o`=0, `cons_take_o`=0, `flush_o`=0 and `fence_o`=1.
- R2: `prod_ready_o` is high exactly when fewer than DEPTH (default 4) commands are stored. A command offered while it is low is not stored, and the producer must hold it.
- R3: Commands leave in the order they were stored, unchanged. The opcode is bits [CMD_W-1 -: OP_W] of the word (default bits 31:29).
- R4: A command whose opcode equals FB_OP (default 4) is taken (`cons_take_o`=1) in every cycle it is at the head. This holds even when `cons_ready_i` is low and even while another command is in progress.
- R5: A non-feedback head is offered (`cons_valid_o`=1) only when no command is in progress. It is taken in a cycle where it is offered and `cons_ready_i` is high.
- R6: Taking a non-feedback command starts an in-progress state. That state ends at the first clock edge where `proc_done_i` is high. A `proc_done_i` pulse while nothing is in progress has no effect.
- R7: `flush_o` is high exactly in the cycles where a command is taken whose opcode bit is set in REDIR_MASK (default opcodes 0, 1 and 2). Each strobe lasts one cycle.
- R8: `fence_o` goes low on the clock edge that stores a command. It goes high on the edge after one at which the queue was empty, nothing was in progress and nothing was stored.
- R9: A store and a take on the same edge leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| reset_i | input | 1 | Synchronous active-high reset |
| prod_valid_i | input | 1 | Producer presents a command |
| prod_data_i | input | CMD_W | Command word, opcode in the top OP_W bits |
| prod_ready_o | output | 1 | Room for one more command |
| cons_valid_o | output | 1 | Head command offered to the consumer |
| cons_data_o | output | CMD_W | Head command word |
| cons_ready_i | input | 1 | Consumer accepts a non-feedback command |
| cons_take_o | output | 1 | Head command is removed this cycle |
| proc_done_i | input | 1 | Consumer finished the command in progress |
| flush_o | output | 1 | One-cycle flush strobe for the opposite fetch queue |
| fence_o | output | 1 | Queue empty and no command in progress |

## Verification
A corrupted occupancy count shows within one cycle as a wrong `prod_ready_o`, or as a head that is offered too early or too late. A stuck in-progress flag holds back the next non-feedback command, or lets it through too soon, and this is visible the first cycle that command reaches the head. A wrong fence register is exposed one edge after any store and two edges after the final done strobe. A wrong class decode shows at once as a missing or extra take or flush in the cycle the command is taken.

// File: rtl/cfq_pkg.sv
package cfq_pkg;

   typedef enum logic [1:0] {
      CLS_OTHER    = 2'd0,
      CLS_FEEDBACK = 2'd1,
      CLS_REDIRECT = 2'd2
   } cmd_class_e;

endpackage

// File: rtl/cfq_classify.sv
module cfq_classify
   import cfq_pkg::*;
#(
   parameter int unsigned OP_W       = 3,
   parameter int unsigned FB_OP      = 4,
   parameter logic [(1<<OP_W)-1:0] REDIR_MASK = '1
) (
   input  logic [OP_W-1:0] op_i,
   output cmd_class_e      cls_o
);

   localparam int unsigned N_OPS = 1 << OP_W;

   initial begin
      assert (FB_OP < N_OPS)
         else $error("cfq_classify: FB_OP outside opcode range");
      assert (REDIR_MASK[FB_OP] == 1'b0)
         else $error("cfq_classify: feedback opcode cannot also redirect");
   end

   logic [N_OPS-1:0] op_onehot;
   logic             hit_fb;
   logic             hit_redir;

   for (genvar g = 0; g < N_OPS; g++) begin : g_dec
      assign op_onehot[g] = (op_i == OP_W'(g));
   end

   assign hit_fb    = op_onehot[FB_OP];
   assign hit_redir = |(op_onehot & REDIR_MASK);

   always_comb begin
      if (hit_fb)         cls_o = CLS_FEEDBACK;
      else if (hit_redir) cls_o = CLS_REDIRECT;
      else                cls_o = CLS_OTHER;
   end

endmodule

// File: rtl/cfq_fifo.sv
module cfq_fifo #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk_i,
   input  logic         reset_i,
   input  logic         push_i,
   input  logic [W-1:0] data_i,
   input  logic         pop_i,
   output logic [W-1:0] data_o,
   output logic         empty_o,
   output logic         full_o
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam bit          POW2  = ((DEPTH & (DEPTH - 1)) == 0);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   initial begin
      assert (DEPTH >= 2) else $error("cfq_fifo: DEPTH must be at least 2");
      assert (W >= 1)     else $error("cfq_fifo: W must be positive");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt_q;

   if (POW2) begin : g_wrap_pow2
      assign wr_nxt = wr_q + 1'b1;
      assign rd_nxt = rd_q + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      assign rd_nxt = (rd_q == LAST) ? '0 : rd_q + 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (reset_i) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_i) wr_q <= wr_nxt;
         if (pop_i)  rd_q <= rd_nxt;
         if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
         else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (push_i) mem[wr_q] <= data_i;
   end

   assign data_o  = mem[rd_q];
   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == CNT_W'(DEPTH));

   // R2: the producer side never writes into a full buffer
   a_r2_no_push_full : assert property (@(posedge clk_i) disable iff (reset_i)
      full_o |-> !push_i);

   // R3: a take only happens when a stored command exists
   a_r3_pop_has_data : assert property (@(posedge clk_i) disable iff (reset_i)
      pop_i |-> !empty_o);

   // R9: simultaneous store and take keep the occupancy
   a_r9_both_keep_level : assert property (@(posedge clk_i) disable iff (reset_i)
      (push_i && pop_i) |=> (full_o == $past(full_o)) && !empty_o);

endmodule

// File: rtl/cfq_ctrl.sv
module cfq_ctrl
   import cfq_pkg::*;
(
   input  logic       clk_i,
   input  logic       reset_i,
   input  logic       head_avail_i,
   input  cmd_class_e head_cls_i,
   input  logic       cons_ready_i,
   input  logic       proc_done_i,
   input  logic       push_i,
   input  logic       fifo_empty_i,
   output logic       cons_valid_o,
   output logic       take_o,
   output logic       flush_o,
   output logic       fence_o
);

   logic busy_q;
   logic fence_q;
   logic head_fb;
   logic take_slow;

   assign head_fb      = head_avail_i && (head_cls_i == CLS_FEEDBACK);
   assign cons_valid_o = head_avail_i && (head_fb || !busy_q);
   assign take_o       = head_fb || (cons_valid_o && cons_ready_i);
   assign take_slow    = take_o && !head_fb;
   assign flush_o      = take_o && (head_cls_i == CLS_REDIRECT);

   always_ff @(posedge clk_i) begin
      if (reset_i) begin
         busy_q  <= 1'b0;
         fence_q <= 1'b1;
      end else begin
         if (take_slow)        busy_q <= 1'b1;
         else if (proc_done_i) busy_q <= 1'b0;
         fence_q <= fifo_empty_i && !busy_q && !push_i;
      end
   end

   assign fence_o = fence_q;

   // R4: a feedback command at the head leaves that same cycle
   a_r4_fb_taken : assert property (@(posedge clk_i) disable iff (reset_i)
      head_fb |-> take_o);

   // R6: no second multi-cycle command starts while one is in progress
   a_r6_busy_blocks : assert property (@(posedge clk_i) disable iff (reset_i)
      busy_q |-> !take_slow);

   // R7: the flush strobe never spans two cycles
   a_r7_flush_single : assert property (@(posedge clk_i) disable iff (reset_i)
      flush_o |=> !flush_o);

   // R8: fence high implies the queue is empty and idle
   a_r8_fence_idle : assert property (@(posedge clk_i) disable iff (reset_i)
      fence_o |-> (fifo_empty_i && !busy_q));

   // R8: a store always pulls the fence low on the next cycle
   a_r8_store_drops_fence : assert property (@(posedge clk_i) disable iff (reset_i)
      push_i |=> !fence_o);

endmodule

// File: rtl/cmd_fence_queue.sv
module cmd_fence_queue
   import cfq_pkg::*;
#(
   parameter int unsigned CMD_W      = 32,
   parameter int unsigned DEPTH      = 4,
   parameter int unsigned OP_W       = 3,
   parameter int unsigned FB_OP      = 4,
   parameter logic [(1<<OP_W)-1:0] REDIR_MASK = (1 << OP_W)'(8'b0000_0111)
) (
   input  logic             clk_i,
   input  logic             reset_i,
   input  logic             prod_valid_i,
   input  logic [CMD_W-1:0] prod_data_i,
   output logic             prod_ready_o,
   output logic             cons_valid_o,
   output logic [CMD_W-1:0] cons_data_o,
   input  logic             cons_ready_i,
   output logic             cons_take_o,
   input  logic             proc_done_i,
   output logic             flush_o,
   output logic             fence_o
);

   initial begin
      assert (OP_W >= 1 && OP_W < CMD_W)
         else $error("cmd_fence_queue: opcode field must fit inside the word");
      assert (OP_W <= 8)
         else $error("cmd_fence_queue: opcode field too wide for mask decode");
   end

   logic       push;
   logic       fifo_empty;
   logic       fifo_full;
   cmd_class_e head_cls;

   assign prod_ready_o = !fifo_full;
   assign push         = prod_valid_i && !fifo_full;

   cfq_fifo #(
      .W     (CMD_W),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk_i   (clk_i),
      .reset_i (reset_i),
      .push_i  (push),
      .data_i  (prod_data_i),
      .pop_i   (cons_take_o),
      .data_o  (cons_data_o),
      .empty_o (fifo_empty),
      .full_o  (fifo_full)
   );

   cfq_classify #(
      .OP_W       (OP_W),
      .FB_OP      (FB_OP),
      .REDIR_MASK (REDIR_MASK)
   ) u_classify (
      .op_i  (cons_data_o[CMD_W-1 -: OP_W]),
      .cls_o (head_cls)
   );

   cfq_ctrl u_ctrl (
      .clk_i        (clk_i),
      .reset_i      (reset_i),
      .head_avail_i (!fifo_empty),
      .head_cls_i   (head_cls),
      .cons_ready_i (cons_ready_i),
      .proc_done_i  (proc_done_i),
      .push_i       (push),
      .fifo_empty_i (fifo_empty),
      .cons_valid_o (cons_valid_o),
      .take_o       (cons_take_o),
      .flush_o      (flush_o),
      .fence_o      (fence_o)
   );

endmodule

// File: tb/tb_cmd_fence_queue.sv
module tb_cmd_fence_queue;

   localparam int W     = 32;
   localparam int DEPTH = 4;

   logic         clk = 1'b0;
   logic         reset_i;
   logic         prod_valid_i;
   logic [W-1:0] prod_data_i;
   logic         prod_ready_o;
   logic         cons_valid_o;
   logic [W-1:0] cons_data_o;
   logic         cons_ready_i;
   logic         cons_take_o;
   logic         proc_done_i;
   logic         flush_o;
   logic         fence_o;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   cmd_fence_queue dut (
      .clk_i        (clk),
      .reset_i      (reset_i),
      .prod_valid_i (prod_valid_i),
      .prod_data_i  (prod_data_i),
      .prod_ready_o (prod_ready_o),
      .cons_valid_o (cons_valid_o),
      .cons_data_o  (cons_data_o),
      .cons_ready_i (cons_ready_i),
      .cons_take_o  (cons_take_o),
      .proc_done_i  (proc_done_i),
      .flush_o      (flush_o),
      .fence_o      (fence_o)
   );

   function automatic logic is_fb(logic [W-1:0] w);
      return w[31:29] == 3'd4;
   endfunction

   function automatic logic is_redir(logic [W-1:0] w);
      return w[31:29] <= 3'd2;
   endfunction

   function automatic logic [W-1:0] mk(int op, int tag);
      return {3'(op), 29'(tag)};
   endfunction

   task automatic check(logic ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference model, built from the requirements
   logic [W-1:0] model[$];
   logic         busy_m  = 1'b0;
   logic         fence_m = 1'b1;

   always @(negedge clk) begin
      if (reset_i) begin
         model.delete();
         busy_m  = 1'b0;
         fence_m = 1'b1;
      end else begin
         logic hv, hfb, exp_valid, exp_take, enq;
         logic [W-1:0] head;
         hv        = model.size() > 0;
         head      = hv ? model[0] : '0;
         hfb       = hv && is_fb(head);
         exp_valid = hv && (hfb || !busy_m);
         exp_take  = hfb || (exp_valid && cons_ready_i);
         check(cons_valid_o == exp_valid, "R5 offer", W'(cons_valid_o), W'(exp_valid));
         if (exp_valid)
            check(cons_data_o == head, "R3 head data", cons_data_o, head);
         check(cons_take_o == exp_take, "R4 take", W'(cons_take_o), W'(exp_take));
         check(flush_o == (exp_take && is_redir(head)), "R7 flush",
               W'(flush_o), W'(exp_take && is_redir(head)));
         check(prod_ready_o == (model.size() < DEPTH), "R2 ready",
               W'(prod_ready_o), W'(model.size() < DEPTH));
         check(fence_o == fence_m, "R8 fence", W'(fence_o), W'(fence_m));
         enq     = prod_valid_i && (model.size() < DEPTH);
         fence_m = (model.size() == 0) && !busy_m && !enq;
         if (exp_take && !hfb)  busy_m = 1'b1;
         else if (proc_done_i)  busy_m = 1'b0;
         if (exp_take) void'(model.pop_front());
         if (enq) model.push_back(prod_data_i);
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic push(logic [W-1:0] w);
      logic ok;
      prod_valid_i = 1'b1;
      prod_data_i  = w;
      do begin
         ok = prod_ready_o;
         tick();
      end while (!ok);
      prod_valid_i = 1'b0;
   endtask

   task automatic done_pulse();
      proc_done_i = 1'b1;
      tick();
      proc_done_i = 1'b0;
   endtask

   task automatic t_reset();
      reset_i = 1'b1;
      prod_valid_i = 1'b0; prod_data_i = '0;
      cons_ready_i = 1'b0; proc_done_i = 1'b0;
      repeat (3) tick();
      reset_i = 1'b0;
      tick();
      check(prod_ready_o == 1'b1, "R1 ready", W'(prod_ready_o), 1);
      check(cons_valid_o == 1'b0, "R1 valid", W'(cons_valid_o), 0);
      check(cons_take_o  == 1'b0, "R1 take",  W'(cons_take_o), 0);
      check(flush_o      == 1'b0, "R1 flush", W'(flush_o), 0);
      check(fence_o      == 1'b1, "R1 fence", W'(fence_o), 1);
   endtask

   task automatic t_fill_stall();
      cons_ready_i = 1'b0;
      for (int i = 0; i < DEPTH; i++) push(mk(3, 16 + i));
      check(prod_ready_o == 1'b0, "R2 full", W'(prod_ready_o), 0);
      check(fence_o == 1'b0, "R8 low when stored", W'(fence_o), 0);
      prod_valid_i = 1'b1; prod_data_i = mk(3, 99);
      repeat (5) tick();
      check(prod_ready_o == 1'b0, "R2 stall", W'(prod_ready_o), 0);
      prod_valid_i = 1'b0;
      cons_ready_i = 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
         check(cons_valid_o && cons_data_o == mk(3, 16 + i), "R3 order",
               cons_data_o, mk(3, 16 + i));
         tick();
         done_pulse();
      end
      check(cons_valid_o == 1'b0, "R2 dropped word absent", W'(cons_valid_o), 0);
      check(fence_o == 1'b0, "R8 lag", W'(fence_o), 0);
      tick();
      check(fence_o == 1'b1, "R8 rise", W'(fence_o), 1);
   endtask

   task automatic t_feedback();
      cons_ready_i = 1'b0;
      push(mk(4, 1));
      check(cons_take_o == 1'b1, "R4 take without ready", W'(cons_take_o), 1);
      tick();
      check(cons_valid_o == 1'b0, "R4 gone", W'(cons_valid_o), 0);
      cons_ready_i = 1'b1;
      push(mk(3, 2));
      tick();                         // command 2 now in progress
      push(mk(4, 3));
      check(cons_take_o == 1'b1, "R4 take while busy", W'(cons_take_o), 1);
      tick();
      push(mk(5, 4));
      check(cons_valid_o == 1'b0, "R6 held while busy", W'(cons_valid_o), 0);
      tick();
      check(cons_valid_o == 1'b0, "R5 still held", W'(cons_valid_o), 0);
      done_pulse();
      check(cons_take_o && cons_data_o == mk(5, 4), "R6 released by done",
            cons_data_o, mk(5, 4));
      tick();
      done_pulse();
      repeat (2) tick();
      // done while idle must not pre-clear the next command
      done_pulse();
      cons_ready_i = 1'b0;
      push(mk(3, 5));
      push(mk(3, 6));
      cons_ready_i = 1'b1;
      #1;
      check(cons_take_o == 1'b1, "R5 take on ready", W'(cons_take_o), 1);
      tick();
      check(cons_valid_o == 1'b0, "R6 idle done ignored", W'(cons_valid_o), 0);
      done_pulse();
      tick();
      done_pulse();
      repeat (2) tick();
   endtask

   task automatic t_flush();
      cons_ready_i = 1'b1;
      for (int op = 0; op < 8; op++) begin
         push(mk(op, 32 + op));
         check(cons_take_o == 1'b1, "R7 taken", W'(cons_take_o), 1);
         check(flush_o == (op <= 2), "R7 flush class", W'(flush_o), W'(op <= 2));
         tick();
         check(flush_o == 1'b0, "R7 one cycle", W'(flush_o), 0);
         if (op != 4) done_pulse();
      end
      repeat (2) tick();
   endtask

   task automatic t_simul();
      cons_ready_i = 1'b0;
      for (int i = 0; i < DEPTH - 1; i++) push(mk(6, 64 + i));
      cons_ready_i = 1'b1;
      push(mk(6, 80));                 // stored on the edge that takes the head
      check(prod_ready_o == 1'b1, "R9 level kept", W'(prod_ready_o), 1);
      for (int i = 1; i < DEPTH - 1; i++) begin
         done_pulse();
         check(cons_data_o == mk(6, 64 + i), "R9 order", cons_data_o, mk(6, 64 + i));
         tick();
      end
      done_pulse();
      check(cons_data_o == mk(6, 80), "R9 last", cons_data_o, mk(6, 80));
      tick();
      done_pulse();
      repeat (2) tick();
      check(fence_o == 1'b1, "R8 final idle", W'(fence_o), 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_fill_stall();
      t_feedback();
      t_flush();
      t_simul();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule